// File: doc/BRIEF.md
# Two-Wire DAC Command Front End

This block is the digital front end of a multi-channel 8-bit DAC that is controlled as a slave on a two-wire serial bus. It samples the bus clock and data lines on the system clock and detects START, repeated START and STOP. It matches a 7-bit write address made of a fixed prefix and three pin-set bits. The bytes that follow are taken as command/data pairs. Each data byte goes into the input latch of the channel the command selects.

At STOP, the device that is addressed at that moment copies its input latches to its output latches and takes its power-down state from the last command it received. A STOP may arrive at any bit position. Complete pairs are always kept and a partial byte is dropped. There is one exception: when the STOP falls inside a data byte, the reset and power-down bits of the command before it still take effect. The parallel output codes drive the analog ladders, which are outside this block.

Top module: `dac_twowire_front`

## Requirements
- R1: A STOP (SDA rising while SCL is high) is recognised at any bit position. It ends the transfer, and the slave neither acknowledges nor accepts bytes until the next START.
- R2: The address byte is acknowledged only if its upper seven bits equal 0101 followed by `dev_pins_i` and its last bit (R/W) is 0. Any other address byte is not acknowledged, and the following bytes are ignored until the next START.
- R3: After a matching address the bytes alternate command, data, command, data. A command byte carries the reset flag in bit 4, the power-down flag in bit 3 and the channel number in bits 2:0, and bits 7:5 are ignored. Every START, repeated or not, makes the next byte a command.
- R4: A data byte is written into the input latch of the channel its command selects. The output latches change only at a STOP that ends a transfer addressed to this device, and at that STOP they take the input latch values.
- R5: The slave pulls SDA low through the ninth clock after a matching address byte and after every command and data byte of a selected transfer. It drives SDA at no other time.
- R6: When STOP arrives inside a command byte, all earlier complete pairs are applied and the partial command has no effect.
- R7: At a STOP of a selected transfer, `pwr_dn_o` takes the power-down bit of the last command byte that was fully received, including one whose data byte was cut off. If no command byte was fully received since the last START, `pwr_dn_o` is left unchanged.
- R8: A command with the reset bit set clears every input latch, and its data byte is not stored. This also applies when STOP arrives inside that data byte. The outputs therefore read 0x00 after the STOP.
- R9: A command that selects a channel number at or above the channel count (4 or 8, set by a parameter) writes no latch.
- R10: While `rst_ni` is low, all input and output latches are 0x00, `pwr_dn_o` is 0 and SDA is released.
- R11: If a repeated START moves a transfer to another device address, input latches already written keep their values and the output latches stay unchanged. A later STOP in a transfer addressed to this device copies those values to the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| dev_pins_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| dac_code_o | output | NCH*8 | Output latch codes, channel n at bits 8n+7:8n |
| pwr_dn_o | output | 1 | Power-down state |

## Verification
The case that is hardest to reach is a STOP cut into the middle of a byte, directly after a command with its reset or power-down bit set. Both the cut position and the command contents have to line up. The bench drives a bus-level master model with a wired-AND data line, and that model can end any byte after 0 to 7 bits. Random transfers mix complete endings, cut commands and cut data bytes with random reset and power-down bits, channel numbers beyond the four channels that are present, R/W=1 and foreign addresses. Directed sequences cover an acknowledge attempt without a START and a repeated START that moves to another device.

// File: rtl/dac_tw_pkg.sv
package dac_tw_pkg;
  localparam int CODE_W = 8;
  localparam logic [3:0] ADDR_PREFIX = 4'b0101;

  typedef struct packed {
    logic       clr;
    logic       pd;
    logic [2:0] ch;
  } dac_cmd_t;
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/tw_byte_rx.sv
module tw_byte_rx
  import dac_tw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sda_i,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [2:0]  dev_pins_i,
  output logic        sel_o,
  output logic        sda_oe_o,
  output logic        pay_vld_o,
  output logic [7:0]  pay_o
);
  logic       active_q, is_addr_q, ack_pend_q;
  logic [3:0] bit_cnt_q;
  logic [6:0] shift_q;
  logic [7:0] rx_byte;
  logic       addr_hit;

  assign rx_byte  = {shift_q, sda_i};
  assign addr_hit = (rx_byte == {ADDR_PREFIX, dev_pins_i, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      is_addr_q  <= 1'b0;
      ack_pend_q <= 1'b0;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      sel_o      <= 1'b0;
      sda_oe_o   <= 1'b0;
      pay_vld_o  <= 1'b0;
      pay_o      <= '0;
    end else begin
      pay_vld_o <= 1'b0;
      if (start_i) begin
        active_q   <= 1'b1;
        is_addr_q  <= 1'b1;
        ack_pend_q <= 1'b0;
        bit_cnt_q  <= '0;
        sel_o      <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        active_q   <= 1'b0;
        ack_pend_q <= 1'b0;
        bit_cnt_q  <= '0;
        sel_o      <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else if (active_q) begin
        if (scl_rise_i && bit_cnt_q < 4'd8) begin
          shift_q   <= {shift_q[5:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (bit_cnt_q == 4'd7) begin
            if (is_addr_q) begin
              is_addr_q <= 1'b0;
              if (addr_hit) begin
                sel_o      <= 1'b1;
                ack_pend_q <= 1'b1;
              end else begin
                active_q <= 1'b0;
              end
            end else begin
              pay_vld_o  <= 1'b1;
              pay_o      <= rx_byte;
              ack_pend_q <= 1'b1;
            end
          end
        end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
          if (!sda_oe_o && ack_pend_q) begin
            sda_oe_o <= 1'b1;
          end else if (sda_oe_o) begin
            sda_oe_o   <= 1'b0;
            ack_pend_q <= 1'b0;
            bit_cnt_q  <= '0;
          end
        end
      end
    end
  end

  AST_ACK_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (bit_cnt_q == 4'd8 && sel_o)) else $error("ack outside slot"); // R5
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sel_o && !sda_oe_o)) else $error("not idle after stop"); // R1
endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank
  import dac_tw_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  sel_i,
  input  logic                  pay_vld_i,
  input  logic [7:0]            pay_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic                  pd_o
);
  dac_cmd_t cmd_q;
  logic     cmd_vld_q, seen_q, pd_next_q;
  logic     pair_done, finish, clr_pair, clr_fin, clr_any;
  logic [CODE_W-1:0] in_q  [NCH];
  logic [CODE_W-1:0] out_q [NCH];

  assign pair_done = pay_vld_i & sel_i & cmd_vld_q;
  assign finish    = stop_i & sel_i;
  assign clr_pair  = pair_done & cmd_q.clr;
  assign clr_fin   = finish & cmd_vld_q & cmd_q.clr;
  assign clr_any   = clr_pair | clr_fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      cmd_vld_q <= 1'b0;
      seen_q    <= 1'b0;
      pd_next_q <= 1'b0;
      pd_o      <= 1'b0;
    end else begin
      if (finish) begin
        if (cmd_vld_q)   pd_o <= cmd_q.pd;
        else if (seen_q) pd_o <= pd_next_q;
      end
      if (start_i || stop_i) begin
        cmd_vld_q <= 1'b0;
        seen_q    <= 1'b0;
      end else if (pay_vld_i && sel_i) begin
        if (!cmd_vld_q) begin
          cmd_q     <= dac_cmd_t'(pay_i[4:0]);
          cmd_vld_q <= 1'b1;
        end else begin
          cmd_vld_q <= 1'b0;
          seen_q    <= 1'b1;
          pd_next_q <= cmd_q.pd;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_en;
    assign wr_en = pair_done & ~cmd_q.clr & (cmd_q.ch == 3'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q[g]  <= '0;
        out_q[g] <= '0;
      end else begin
        if (clr_any)    in_q[g] <= '0;
        else if (wr_en) in_q[g] <= pay_i;
        if (finish)     out_q[g] <= clr_fin ? '0 : in_q[g];
      end
    end

    assign code_o[g*CODE_W +: CODE_W] = out_q[g];
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_i && sel_i) |=> $stable(code_o)) else $error("outputs moved without stop"); // R4
  AST_PD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_i && sel_i) |=> $stable(pd_o)) else $error("power-down moved without stop"); // R7
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && sel_i && cmd_vld_q && cmd_q.clr) |=> (code_o == '0)) else $error("reset at stop"); // R8
  AST_START_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !cmd_vld_q) else $error("pair position not reset"); // R3
endmodule

// File: rtl/dac_twowire_front.sv
module dac_twowire_front
  import dac_tw_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [2:0]            dev_pins_i,
  output logic                  sda_oe_o,
  output logic [NCH*CODE_W-1:0] dac_code_o,
  output logic                  pwr_dn_o
);
  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic sel, pay_vld;
  logic [7:0] pay;

  tw_pin_sync #(.STAGES(SYNC_STGS)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  tw_byte_rx i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .dev_pins_i (dev_pins_i),
    .sel_o      (sel),
    .sda_oe_o   (sda_oe_o),
    .pay_vld_o  (pay_vld),
    .pay_o      (pay)
  );

  dac_latch_bank #(.NCH(NCH)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_p),
    .stop_i    (stop_p),
    .sel_i     (sel),
    .pay_vld_i (pay_vld),
    .pay_i     (pay),
    .code_o    (dac_code_o),
    .pd_o      (pwr_dn_o)
  );
endmodule

// File: tb/test_dac_twowire_front.sv
module test_dac_twowire_front;
  localparam int NCH = 4;
  localparam int Q = 6;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [6:0] OWN = {4'b0101, PINS};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NCH*8-1:0] code;
  logic pd;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  dac_twowire_front #(.NCH(NCH)) i_dac_twowire_front (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .dev_pins_i(PINS), .sda_oe_o(sda_oe), .dac_code_o(code), .pwr_dn_o(pd)
  );

  logic [7:0] m_in [NCH];
  logic [7:0] m_out[NCH];
  logic [7:0] m_cmd;
  logic m_pd, m_sel, m_cmdv, m_seen, m_pdn;
  bit bus_idle = 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  // reference model
  task automatic m_clear();
    for (int i = 0; i < NCH; i++) m_in[i] = 8'h00;
  endtask
  task automatic m_start();
    m_sel = 0; m_cmdv = 0; m_seen = 0;
  endtask
  task automatic m_pay(input logic [7:0] b);
    if (!m_sel) return;
    if (!m_cmdv) begin
      m_cmd = b; m_cmdv = 1;
    end else begin
      m_cmdv = 0; m_seen = 1; m_pdn = m_cmd[3];
      if (m_cmd[4]) m_clear();
      else if (int'(m_cmd[2:0]) < NCH) m_in[m_cmd[2:0]] = b;
    end
  endtask
  task automatic m_stop();
    if (m_sel) begin
      if (m_cmdv) begin
        if (m_cmd[4]) m_clear();
        m_pdn = m_cmd[3]; m_seen = 1;
      end
      for (int i = 0; i < NCH; i++) m_out[i] = m_in[i];
      if (m_seen) m_pd = m_pdn;
    end
    m_sel = 0; m_cmdv = 0; m_seen = 0;
  endtask

  // bus master
  task automatic b_start();
    if (!bus_idle) begin
      sda_m = 1; wq(); scl_m = 1; wq();
    end
    sda_m = 0; wq(); scl_m = 0; wq();
    bus_idle = 0;
    m_start();
  endtask
  task automatic b_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; wq(); scl_m = 1; wq(2); scl_m = 0; wq();
    end
  endtask
  task automatic b_ack(input string req, input logic exp);
    logic seen;
    sda_m = 1; wq(); scl_m = 1; wq();
    seen = sda_oe;
    wq(); scl_m = 0; wq();
    check(req, 32'(seen), 32'(exp));
  endtask
  task automatic b_addr(input logic [6:0] a, input logic rw);
    b_bits({a, rw}, 8);
    m_sel = (a == OWN) && !rw;
    b_ack("R2 address ack", m_sel);
  endtask
  task automatic b_pay(input logic [7:0] b);
    logic exp;
    b_bits(b, 8);
    exp = m_sel;
    m_pay(b);
    b_ack("R5 byte ack", exp);
  endtask
  task automatic b_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(2);
    bus_idle = 1;
    m_stop();
  endtask
  task automatic chk_outs(input string req);
    for (int i = 0; i < NCH; i++) check(req, 32'(code[i*8 +: 8]), 32'(m_out[i]));
    check({req, " pd"}, 32'(pd), 32'(m_pd));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_clear();
    for (int i = 0; i < NCH; i++) m_out[i] = 8'h00;
    m_pd = 0; m_start(); m_pdn = 0; m_cmd = 0;
    repeat (5) @(negedge clk);
    // R10 reset state
    check("R10 codes", 32'(code), 32'(0));
    check("R10 pd", 32'(pd), 0);
    check("R10 sda", 32'(sda_oe), 0);
    rst_n = 1; wq();

    // R4 basic writes
    b_start(); b_addr(OWN, 0);
    b_pay(8'h01); b_pay(8'hA5);
    b_pay(8'hE3); b_pay(8'h3C);   // reserved bits set, channel 3
    b_stop(); wq(); chk_outs("R4");

    // R2 foreign address and read bit
    b_start(); b_addr(OWN ^ 7'h02, 0); b_pay(8'h02); b_pay(8'h55); b_stop(); wq();
    chk_outs("R2 foreign");
    b_start(); b_addr(OWN, 1); b_pay(8'h00); b_pay(8'h66); b_stop(); wq();
    chk_outs("R2 read bit");

    // R1 no ack without START after a STOP
    b_bits(8'h00, 8); b_ack("R1 no ack after stop", 0); b_stop(); wq();

    // R6 stop inside command byte
    b_start(); b_addr(OWN, 0); b_pay(8'h00); b_pay(8'h11);
    b_bits(8'h0A, 3); b_stop(); wq(); chk_outs("R6");

    // R7 stop inside data byte after power-down command
    b_start(); b_addr(OWN, 0); b_pay(8'h09); b_bits(8'hFF, 5); b_stop(); wq();
    chk_outs("R7");
    check("R7 pd set", 32'(pd), 1);

    // R8 reset command with data cut off
    b_start(); b_addr(OWN, 0); b_pay(8'h12); b_pay(8'h99);
    b_pay(8'h10); b_bits(8'h77, 2); b_stop(); wq();
    chk_outs("R8");
    check("R8 zero", 32'(code), 32'(0));

    // R9 channel beyond channel count
    b_start(); b_addr(OWN, 0); b_pay(8'h00); b_pay(8'h42);
    b_pay(8'h06); b_pay(8'hBB); b_stop(); wq(); chk_outs("R9");

    // R11 repeated START to another device
    b_start(); b_addr(OWN, 0); b_pay(8'h02); b_pay(8'h77);
    b_start(); b_addr(OWN ^ 7'h01, 0); b_pay(8'h02); b_pay(8'hFF);
    b_stop(); wq(); chk_outs("R11 hold");
    b_start(); b_addr(OWN, 0); b_stop(); wq(); chk_outs("R11 copy");
    check("R11 ch2", 32'(code[23:16]), 32'h77);

    // random transfers
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a;
      logic rw;
      int np, endk, cut;
      a   = (($urandom % 5) != 0) ? OWN : {4'b0101, PINS ^ 3'(1 + $urandom % 7)};
      rw  = (($urandom % 8) == 0);
      np  = $urandom % 4;
      endk = $urandom % 3;
      cut = $urandom % 8;
      b_start(); b_addr(a, rw);
      for (int p = 0; p < np; p++) begin
        logic [7:0] c;
        c = {3'($urandom), (($urandom % 10) == 0), 1'($urandom), 3'($urandom)};
        b_pay(c); b_pay(8'($urandom));
      end
      if (endk == 1) b_bits(8'($urandom), cut);
      if (endk == 2) begin
        b_pay({3'b0, (($urandom % 4) == 0), 1'($urandom), 3'($urandom)});
        b_bits(8'($urandom), cut);
      end
      b_stop(); wq();
      chk_outs("R1 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule